// File: doc/BRIEF.md
# Four-Channel DMA Transfer Sequencer

This block arbitrates between four peripheral request lines and runs single memory transfers on behalf of the winner. Software loads each channel's 16-bit start address and 14-bit count through a register-write port, then writes an 8-bit mode word. The mode word enables channels, picks fixed or rotating priority, and turns on three options: disable-after-terminal-count, early write strobe, and chained reload of channel 2 from channel 3.

When an enabled channel raises its request, the sequencer asks the host for the bus. Once the host acknowledges, it picks one channel and runs a two-cycle transfer. During that transfer it pulls the channel's acknowledge low, drives the channel's current address, and raises the write strobe. At the end of the transfer it advances the address, decrements the count and updates the priority order. While requests remain, the bus stays held. A terminal-count pulse marks the last transfer of a block, and a mark pulse flags every 128th transfer. Sticky per-channel terminal-count flags can be read, and a read-clear strobe clears them.

Top module: `dma4_sequencer`

## Requirements
- R1: After reset the mode word and the status flags are zero. `hold_req_o`, `wr_strobe_o`, `tc_o` and `mark_o` are low, every `dack_n_o` bit is high, and no request can raise `hold_req_o` until the mode word is written.
- R2: Writes decode `reg_addr_i` as follows. Values 0..7 select channel `reg_addr_i[2:1]`. With `reg_addr_i[0]`=0 the write loads the address register; with `reg_addr_i[0]`=1 it loads the count register from the low 14 bits. Value 8 loads the mode word from `reg_wdata_i[7:0]`: bit7 chain-reload, bit6 stop-at-terminal-count, bit5 early-write, bit4 rotating priority, bits3..0 enables for channels 3..0.
- R3: An enabled request raises `hold_req_o` one cycle later. `dack_n_o` stays high while `hold_ack_i` is low. In the cycle after `hold_ack_i` is seen high, a transfer starts. The transfer lasts two cycles. During both cycles exactly one `dack_n_o` bit is low and `mem_addr_o` shows that channel's current address. After the last request is withdrawn, `hold_req_o` drops.
- R4: A request on a channel whose enable bit is 0 is ignored and never raises `hold_req_o`.
- R5: With bit4 = 0, the lowest-numbered pending channel wins every time.
- R6: With bit4 = 1, the channel serviced last becomes lowest in priority and the next channel number becomes highest.
- R7: Each transfer increments the address and decrements the count. A count value of N gives N+1 transfers. `tc_o` is high in the second cycle of the transfer made with count 0, and only then.
- R8: With bit6 = 1, a terminal count clears that channel's enable bit, so its later requests are ignored. With bit6 = 0, the channel stays enabled and its count wraps to all ones.
- R9: `mark_o` is high in the second cycle of every 128th transfer counted from the last count-register load, and low on every other transfer.
- R10: With bit5 = 1, `wr_strobe_o` is high in both transfer cycles. With bit5 = 0, it is high only in the second cycle.
- R11: `status_o[i]` is set by a terminal count on channel i and stays set until `stat_rd_i` is pulsed. A set in the same cycle as the clear wins.
- R12: With bit7 = 1, a terminal count on channel 2 reloads channel 2's address and count from channel 3's registers. Channel 2 then stays enabled even when bit6 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| stat_rd_i | input | 1 | Read-clear pulse for the status flags |
| status_o | output | 4 | Sticky terminal-count flag per channel |
| dreq_i | input | 4 | Peripheral transfer requests |
| hold_req_o | output | 1 | Bus request to the host |
| hold_ack_i | input | 1 | Bus grant from the host |
| dack_n_o | output | 4 | Active-low channel acknowledges |
| mem_addr_o | output | 16 | Address of the current transfer |
| wr_strobe_o | output | 1 | Write strobe |
| tc_o | output | 1 | Terminal-count pulse |
| mark_o | output | 1 | Every-128th-transfer pulse |

## Verification
A request driven before a clock edge shows up on `hold_req_o` after that edge. With the bus already granted, the acknowledge falls one edge later. `tc_o`, `mark_o` and the second-cycle strobe follow one edge after that. Updated addresses, counts, enables and status flags are visible after the edge that ends the transfer. The bench drives and samples only on falling edges. It waits for the falling edge where an acknowledge first appears and treats that as the first transfer cycle, then checks the terminal-count, mark and strobe values on the next falling edge. It withdraws requests on that second-cycle edge, so the sequencer falls idle exactly after the transfer under test.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

    localparam int NCH    = 4;
    localparam int IW     = $clog2(NCH);
    localparam int AL_DST = 2;
    localparam int AL_SRC = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_S1,
        ST_S2
    } seq_state_e;

    // Field order is the software-visible mode layout (msb first).
    typedef struct packed {
        logic           auto_load;
        logic           tc_stop;
        logic           ext_wr;
        logic           rot_prio;
        logic [NCH-1:0] en;
    } mode_t;

    typedef struct packed {
        seq_state_e     st;
        logic           hreq;
        logic [IW-1:0]  gnt;
        logic [IW-1:0]  rbase;
        mode_t          mode;
        logic [NCH-1:0] flags;
    } core_t;

endpackage

// File: rtl/dma4_prio_pick.sv
module dma4_prio_pick #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req_i,
    input  logic [IW-1:0]  base_i,
    output logic           valid_o,
    output logic [IW-1:0]  idx_o
);

    // Scan from base_i upward with wrap; NCH is a power of two.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = 0; i < NCH; i++) begin
            logic [IW-1:0] cand;
            cand = base_i + IW'(i);
            if (!valid_o && req_i[cand]) begin
                valid_o = 1'b1;
                idx_o   = cand;
            end
        end
    end

endmodule

// File: rtl/dma4_chan.sv
module dma4_chan #(
    parameter int AW    = 16,
    parameter int CW    = 14,
    parameter int MARKP = 128,
    localparam int MW   = $clog2(MARKP)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ld_addr_i,
    input  logic          ld_cnt_i,
    input  logic [AW-1:0] wdata_i,
    input  logic          step_i,
    input  logic          reload_i,
    input  logic [AW-1:0] reload_addr_i,
    input  logic [CW-1:0] reload_cnt_i,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o,
    output logic          at_tc_o,
    output logic          at_mark_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic [MW-1:0] done;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reload_i) begin
            st_d.addr = reload_addr_i;
            st_d.cnt  = reload_cnt_i;
            st_d.done = '0;
        end else if (step_i) begin
            st_d.addr = st_q.addr + AW'(1);
            st_d.cnt  = st_q.cnt - CW'(1);
            st_d.done = st_q.done + MW'(1);
        end
        if (ld_addr_i) begin
            st_d.addr = wdata_i;
        end
        if (ld_cnt_i) begin
            st_d.cnt  = wdata_i[CW-1:0];
            st_d.done = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign cnt_o     = st_q.cnt;
    assign at_tc_o   = (st_q.cnt == '0);
    assign at_mark_o = (st_q.done == MW'(MARKP - 1));

    assert_step_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !reload_i && !ld_cnt_i) |=> (cnt_o == ($past(cnt_o) - CW'(1))));

    assert_step_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !reload_i && !ld_addr_i) |=> (addr_o == ($past(addr_o) + AW'(1))));

    assert_reload_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_i && !ld_cnt_i) |=> (cnt_o == $past(reload_cnt_i)));

endmodule

// File: rtl/dma4_sequencer.sv
module dma4_sequencer
    import dma4_pkg::*;
#(
    parameter int AW    = 16,
    parameter int CW    = 14,
    parameter int MARKP = 128
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           reg_we_i,
    input  logic [3:0]     reg_addr_i,
    input  logic [AW-1:0]  reg_wdata_i,
    input  logic           stat_rd_i,
    output logic [NCH-1:0] status_o,
    input  logic [NCH-1:0] dreq_i,
    output logic           hold_req_o,
    input  logic           hold_ack_i,
    output logic [NCH-1:0] dack_n_o,
    output logic [AW-1:0]  mem_addr_o,
    output logic           wr_strobe_o,
    output logic           tc_o,
    output logic           mark_o
);

    localparam int MODE_W = $bits(mode_t);
    localparam logic [3:0] MODE_SEL = 4'(1 << (IW + 1));

    core_t c_d, c_q;

    logic [AW-1:0]  ch_addr [NCH];
    logic [CW-1:0]  ch_cnt  [NCH];
    logic [NCH-1:0] ch_tc, ch_mark;
    logic [NCH-1:0] ld_addr, ld_cnt, step;
    logic           mode_we;
    logic           busy, tc_now, mark_now, al_reload;
    logic           pick_vld;
    logic [IW-1:0]  pick_idx, pick_base;
    logic [NCH-1:0] eligible, eligible_nx;

    // Register write decode
    assign mode_we = reg_we_i && (reg_addr_i == MODE_SEL);

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign ld_addr[i] = reg_we_i && !reg_addr_i[IW+1] &&
                            (reg_addr_i[IW:1] == IW'(i)) && !reg_addr_i[0];
        assign ld_cnt[i]  = reg_we_i && !reg_addr_i[IW+1] &&
                            (reg_addr_i[IW:1] == IW'(i)) && reg_addr_i[0];
    end

    // Channel register slices
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic          rl;
        logic [AW-1:0] rl_addr;
        logic [CW-1:0] rl_cnt;
        if (i == AL_DST) begin : g_chain
            assign rl      = al_reload;
            assign rl_addr = ch_addr[AL_SRC];
            assign rl_cnt  = ch_cnt[AL_SRC];
        end else begin : g_plain
            assign rl      = 1'b0;
            assign rl_addr = '0;
            assign rl_cnt  = '0;
        end
        dma4_chan #(
            .AW   (AW),
            .CW   (CW),
            .MARKP(MARKP)
        ) u_chan (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .ld_addr_i    (ld_addr[i]),
            .ld_cnt_i     (ld_cnt[i]),
            .wdata_i      (reg_wdata_i),
            .step_i       (step[i]),
            .reload_i     (rl),
            .reload_addr_i(rl_addr),
            .reload_cnt_i (rl_cnt),
            .addr_o       (ch_addr[i]),
            .cnt_o        (ch_cnt[i]),
            .at_tc_o      (ch_tc[i]),
            .at_mark_o    (ch_mark[i])
        );
    end

    // Priority picker
    assign eligible  = dreq_i & c_q.mode.en;
    assign pick_base = c_q.mode.rot_prio ? c_q.rbase : '0;

    dma4_prio_pick #(.NCH(NCH)) u_pick (
        .req_i  (eligible),
        .base_i (pick_base),
        .valid_o(pick_vld),
        .idx_o  (pick_idx)
    );

    assign busy      = (c_q.st == ST_S1) || (c_q.st == ST_S2);
    assign tc_now    = (c_q.st == ST_S2) && ch_tc[c_q.gnt];
    assign mark_now  = (c_q.st == ST_S2) && ch_mark[c_q.gnt];
    assign al_reload = tc_now && c_q.mode.auto_load && (c_q.gnt == IW'(AL_DST));

    always_comb begin
        step = '0;
        if (c_q.st == ST_S2) begin
            step[c_q.gnt] = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        c_d = c_q;

        if (stat_rd_i) begin
            c_d.flags = '0;
        end
        if (tc_now) begin
            c_d.flags[c_q.gnt] = 1'b1;
        end
        if (tc_now && c_q.mode.tc_stop && !al_reload) begin
            c_d.mode.en[c_q.gnt] = 1'b0;
        end
        if (mode_we) begin
            c_d.mode = mode_t'(reg_wdata_i[MODE_W-1:0]);
        end

        eligible_nx = dreq_i & c_d.mode.en;

        unique case (c_q.st)
            ST_IDLE: begin
                if (|eligible) begin
                    c_d.hreq = 1'b1;
                    c_d.st   = ST_REQ;
                end
            end
            ST_REQ: begin
                if (!pick_vld) begin
                    c_d.hreq = 1'b0;
                    c_d.st   = ST_IDLE;
                end else if (hold_ack_i) begin
                    c_d.gnt = pick_idx;
                    c_d.st  = ST_S1;
                end
            end
            ST_S1: begin
                c_d.st = ST_S2;
            end
            ST_S2: begin
                c_d.rbase = c_q.gnt + IW'(1);
                if (|eligible_nx) begin
                    c_d.st = ST_REQ;
                end else begin
                    c_d.hreq = 1'b0;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    // Outputs
    always_comb begin
        dack_n_o = '1;
        if (busy) begin
            dack_n_o[c_q.gnt] = 1'b0;
        end
    end

    assign mem_addr_o  = busy ? ch_addr[c_q.gnt] : '0;
    assign wr_strobe_o = (c_q.st == ST_S2) || ((c_q.st == ST_S1) && c_q.mode.ext_wr);
    assign tc_o        = tc_now;
    assign mark_o      = mark_now;
    assign hold_req_o  = c_q.hreq;
    assign status_o    = c_q.flags;

    // Assertions
    assert_dack_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(~dack_n_o));

    assert_dack_in_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dack_n_o != '1) |-> hold_req_o);

    assert_hold_needs_enabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hold_req_o) |-> $past(|(dreq_i & c_q.mode.en)));

    assert_tc_in_xfer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_o |-> ((dack_n_o != '1) && wr_strobe_o));

    assert_tc_disable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tc_o && c_q.mode.tc_stop && !al_reload && !mode_we)
        |=> !c_q.mode.en[$past(c_q.gnt)]);

    assert_tc_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_o |=> status_o[$past(c_q.gnt)]);

endmodule

// File: tb/dma4_sequencer_bench.sv
`timescale 1ns/1ps
module dma4_sequencer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        stat_rd;
    logic [3:0]  status;
    logic [3:0]  dreq;
    logic        hold_req;
    logic        hold_ack;
    logic [3:0]  dack_n;
    logic [15:0] mem_addr;
    logic        wr_strobe;
    logic        tc;
    logic        mark;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    dma4_sequencer u_dma4_sequencer (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .reg_we_i   (reg_we),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .stat_rd_i  (stat_rd),
        .status_o   (status),
        .dreq_i     (dreq),
        .hold_req_o (hold_req),
        .hold_ack_i (hold_ack),
        .dack_n_o   (dack_n),
        .mem_addr_o (mem_addr),
        .wr_strobe_o(wr_strobe),
        .tc_o       (tc),
        .mark_o     (mark)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Wait for the first transfer cycle; returns channel index and address.
    task automatic wait_grant(output int ch, output logic [15:0] a, output bit found);
        found = 1'b0; ch = -1; a = '0;
        for (int k = 0; k < 20 && !found; k++) begin
            @(negedge clk);
            if (dack_n != 4'hF) begin
                found = 1'b1;
                for (int j = 0; j < 4; j++) if (!dack_n[j]) ch = j;
                a = mem_addr;
            end
        end
    endtask

    // One transfer: check channel, address, then tc/mark in cycle two.
    task automatic xfer(input string rq, input int exp_ch, input logic [15:0] exp_a,
                        input bit exp_tc, input bit exp_mark, input bit drop);
        int ch; logic [15:0] a; bit found;
        wait_grant(ch, a, found);
        chk(found && ch == exp_ch, rq, "granted channel", ch, exp_ch);
        chk(a == exp_a, rq, "transfer address", a, exp_a);
        @(negedge clk);
        chk(dack_n[exp_ch] == 1'b0, rq, "dack held in cycle two", dack_n, exp_ch);
        chk(tc == exp_tc, rq, "tc pulse", tc, exp_tc);
        chk(mark == exp_mark, rq, "mark pulse", mark, exp_mark);
        if (drop) dreq = 4'h0;
    endtask

    task automatic expect_no_hold(input string rq, input int n);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (hold_req || dack_n != 4'hF) seen = 1'b1;
        end
        chk(!seen, rq, "request ignored, hold stays low", seen, 0);
        dreq = 4'h0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(hold_req == 1'b0, "R1", "hold after reset", hold_req, 0);
        chk(dack_n == 4'hF, "R1", "dack after reset", dack_n, 4'hF);
        chk(status == 4'h0, "R1", "status after reset", status, 0);
        chk(!tc && !mark && !wr_strobe, "R1", "strobes after reset",
            {tc, mark, wr_strobe}, 0);
        dreq = 4'hF;
        expect_no_hold("R1", 6);
    endtask

    task automatic t_handshake();
        int ch; logic [15:0] a; bit found;
        wr_reg(4'h0, 16'h1234);   // R2 ch0 address
        wr_reg(4'h1, 16'h0005);   // R2 ch0 count
        wr_reg(4'h8, 16'h0001);   // R2 enable ch0
        @(negedge clk);
        hold_ack = 1'b0; dreq = 4'b0001;
        @(negedge clk);
        chk(hold_req == 1'b1, "R3", "hold one cycle after request", hold_req, 1);
        @(negedge clk);
        chk(dack_n == 4'hF, "R3", "no dack without grant", dack_n, 4'hF);
        hold_ack = 1'b1;
        wait_grant(ch, a, found);
        chk(found && ch == 0, "R3", "grant after ack", ch, 0);
        chk(a == 16'h1234, "R2", "address register load", a, 16'h1234);
        @(negedge clk);
        chk(dack_n == 4'b1110, "R3", "two-cycle dack", dack_n, 4'b1110);
        dreq = 4'h0;
        @(negedge clk);
        chk(hold_req == 1'b0 && dack_n == 4'hF, "R3", "hold released",
            {hold_req, dack_n}, 5'h0F);
    endtask

    task automatic t_disabled();
        wr_reg(4'h8, 16'h0007);
        @(negedge clk);
        dreq = 4'b1000;
        expect_no_hold("R4", 6);
    endtask

    task automatic t_fixed();
        for (int c = 0; c < 4; c++) begin
            wr_reg(4'(2*c), 16'(16'h0100 * (c + 1)));
            wr_reg(4'(2*c + 1), 16'd100);
        end
        wr_reg(4'h8, 16'h000F);
        @(negedge clk);
        dreq = 4'hF;
        xfer("R5", 0, 16'h0100, 0, 0, 0);
        xfer("R5", 0, 16'h0101, 0, 0, 0);
        xfer("R5", 0, 16'h0102, 0, 0, 1);
        @(negedge clk);
        dreq = 4'b1110;
        xfer("R5", 1, 16'h0200, 0, 0, 1);
    endtask

    task automatic t_rotate();
        wr_reg(4'h8, 16'h001F);
        @(negedge clk);
        dreq = 4'hF;
        // ch1 served last, so ch2 leads
        xfer("R6", 2, 16'h0300, 0, 0, 0);
        xfer("R6", 3, 16'h0400, 0, 0, 0);
        xfer("R6", 0, 16'h0103, 0, 0, 0);
        xfer("R6", 1, 16'h0201, 0, 0, 0);
        xfer("R6", 2, 16'h0301, 0, 0, 1);
    endtask

    task automatic t_count_tc();
        wr_reg(4'h0, 16'h1234);
        wr_reg(4'h1, 16'h0002);
        wr_reg(4'h8, 16'h0041);
        @(negedge clk);
        dreq = 4'b0001;
        xfer("R7", 0, 16'h1234, 0, 0, 0);
        xfer("R7", 0, 16'h1235, 0, 0, 0);
        xfer("R7", 0, 16'h1236, 1, 0, 1);
        @(negedge clk);
        chk(status == 4'b0001, "R11", "sticky tc flag", status, 4'b0001);
        dreq = 4'b0001;
        expect_no_hold("R8", 6);
        chk(status == 4'b0001, "R11", "flag holds", status, 4'b0001);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        chk(status == 4'b0000, "R11", "read clears", status, 0);
        // stop-at-tc off: channel 1 survives and wraps
        wr_reg(4'h2, 16'h2000);
        wr_reg(4'h3, 16'h0000);
        wr_reg(4'h8, 16'h0002);
        @(negedge clk);
        dreq = 4'b0010;
        xfer("R8", 1, 16'h2000, 1, 0, 1);
        @(negedge clk);
        dreq = 4'b0010;
        xfer("R8", 1, 16'h2001, 0, 0, 1);
        @(negedge clk);
        chk(status == 4'b0010, "R11", "flag of channel 1", status, 4'b0010);
    endtask

    task automatic t_mark();
        wr_reg(4'h6, 16'h0000);
        wr_reg(4'h7, 16'd200);
        wr_reg(4'h8, 16'h0008);
        @(negedge clk);
        dreq = 4'b1000;
        for (int n = 1; n <= 130; n++) begin
            xfer("R9", 3, 16'(n - 1), 0, (n == 128), (n == 130));
        end
    endtask

    task automatic t_ew();
        int ch; logic [15:0] a; bit found;
        wr_reg(4'h1, 16'h0010);
        wr_reg(4'h8, 16'h0021);
        @(negedge clk);
        dreq = 4'b0001;
        wait_grant(ch, a, found);
        chk(found && wr_strobe == 1'b1, "R10", "early strobe in cycle one", wr_strobe, 1);
        @(negedge clk);
        chk(wr_strobe == 1'b1, "R10", "strobe in cycle two", wr_strobe, 1);
        dreq = 4'h0;
        wr_reg(4'h8, 16'h0001);
        @(negedge clk);
        dreq = 4'b0001;
        wait_grant(ch, a, found);
        chk(found && wr_strobe == 1'b0, "R10", "no strobe in cycle one", wr_strobe, 0);
        @(negedge clk);
        chk(wr_strobe == 1'b1, "R10", "normal strobe in cycle two", wr_strobe, 1);
        dreq = 4'h0;
    endtask

    task automatic t_autoload();
        wr_reg(4'h4, 16'h0100);
        wr_reg(4'h5, 16'h0000);
        wr_reg(4'h6, 16'h4000);
        wr_reg(4'h7, 16'h0001);
        wr_reg(4'h8, 16'h00C4);
        @(negedge clk);
        dreq = 4'b0100;
        xfer("R12", 2, 16'h0100, 1, 0, 0);
        xfer("R12", 2, 16'h4000, 0, 0, 0);
        xfer("R12", 2, 16'h4001, 1, 0, 1);
        @(negedge clk);
        chk(status[2] == 1'b1, "R12", "tc flag of chained channel", status[2], 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        stat_rd = 1'b0; dreq = '0; hold_ack = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_handshake();
        t_disabled();
        t_fixed();
        t_rotate();
        t_count_tc();
        t_mark();
        t_ew();
        t_autoload();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule